// File: doc/BRIEF.md
# Vector Unpack Engine

The engine takes a stream of 32-bit words and turns it into 128-bit vectors of four 32-bit lanes. Each vector is written into a vector data memory. A short command sets the element format, the number of elements per vector and whether the lane mask is used. The command also carries a vector count and a 16-bit immediate that gives the start address.

A pair of cycle values controls the write pattern. CL is the number of positions that take stream data in each group, and WL is the group length. When CL is larger than WL, groups of positions are spread out with gaps between them. When CL is smaller than WL, the positions past CL are filled in without using any stream data.

Each lane goes through a two-bit selector. The selector picks the unpacked element, a row register, a column register, or the value already in memory. An optional add-row or accumulate-row step follows.

The engine talks to a synchronous memory with a one-cycle read latency. For every vector it first reads the old contents at the target address, then writes the new value to the same address. Stream words are taken with a valid/ready handshake, and only when the engine needs one. The configuration inputs (CL, WL, mode, mask, TOPS, column registers) must be held stable while the engine is busy. The four row registers live inside the engine, because accumulate mode writes back into them.

Top module: `vu_unpack_engine`

## Requirements
- R1: Command field decoding:
  - `cmd_fmt[1:0]` selects the element format: 0 = 32-bit, 1 = 16-bit, 2 = 8-bit, 3 = packed 5/5/5/1.
  - `cmd_fmt[3:2]` holds E, and each vector uses E+1 elements.
  - `cmd_fmt[4]` enables the mask.
  - Elements are taken from the stream as one continuous run of bits, low bits of each word first. A new command always starts at a fresh word.
- R2: 16-bit elements come two per word and 8-bit elements four per word. Each element is sign-extended to 32 bits.
- R3: The packed format uses one whole word per vector. Bits [4:0], [9:5] and [14:10] are sign-extended into lanes 0 to 2. Bit 15 is sign-extended into lane 3, giving 0 or all ones. Bits [31:16] are ignored.
- R4: When E = 0, element 0 is copied into all four lanes. When E is 1 or 2, the lanes above E take zero.
- R5: Addressing:
  - The start address is `imm[9:0]`. When `imm[15]` is set, TOPS is added to it.
  - Position v is written at start + CL*(v div W) + (v mod W), wrapping at 2^AW. W is WL, with a WL of 0 meaning 256.
  - The command writes `cmd_num` positions, with 0 meaning 256.
- R6: When CL < W, a position with (v mod W) >= CL uses no stream data, and its unpacked lanes are zero.
- R7: Lane mask:
  - When the mask is enabled, lane i takes its selector from `cfg_mask[8*r+2*i +: 2]`, where r = min(v mod W, 3).
  - Selector values: 0 = unpacked lane, 1 = row register i, 2 = column register min(v,3), 3 = old memory lane.
  - When the mask is disabled, every lane takes the unpacked value.
- R8: Mode:
  - Mode 1 adds row register i to lane i.
  - Mode 2 does the same add and then stores the sum back into row register i.
  - Modes 0 and 3 pass the lanes through unchanged.
  - The mode step applies to all four lanes, after the mask.
- R9: A command with format 3 and E != 3 is invalid:
  - `err` is set, `done` pulses, and no word is taken or written.
  - `err` holds until the next command is accepted.
- R10: A command takes exactly ceil(total element bits / 32) stream words. `s_ready` is high only while a word is needed.
- R11: For each vector there is exactly one read, then exactly one write to the same address two cycles later. A read and a write never happen in the same cycle.
- R12: After reset the engine is idle with `cmd_ready` high. `busy` is high from acceptance until the final write, and `done` is a one-cycle pulse when the command ends.
- R13: `row_ld` loads the row registers only while idle. While busy it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command accepted |
| cmd_fmt | input | 5 | Mask enable, element count, element format |
| cmd_num | input | 8 | Number of positions, 0 means 256 |
| cmd_imm | input | 16 | Start address [9:0], TOPS-relative flag [15] |
| cfg_cl | input | 8 | Data positions per group (CL) |
| cfg_wl | input | 8 | Group length (WL), 0 means 256 |
| cfg_mode | input | 2 | 0 pass, 1 add row, 2 accumulate row |
| cfg_mask | input | 32 | Four rows of four 2-bit lane selectors |
| cfg_tops | input | 10 | Offset added when imm[15] is set |
| cfg_col | input | 128 | Column registers C0..C3, C0 in bits [31:0] |
| row_ld | input | 1 | Load row registers (idle only) |
| row_ld_data | input | 128 | Row register load value, lane 0 low |
| row_q | output | 128 | Current row registers |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word taken |
| s_data | input | 32 | Stream word |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory vector address |
| mem_rdata | input | 128 | Read data, one cycle after the strobe |
| mem_wdata | output | 128 | Write data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Last command had an invalid format |

## Verification
The bench targets several corner cases:
- The stream bit offset carried between vectors in the 16-bit and 8-bit formats. A design that restarts at a fresh word for each vector takes too many words and shifts every later element.
- Fill positions. These must take zero data and use no words, so a wrong skip test takes too many words.
- Overlapping addresses in fill mode, which force a later vector to read the value an earlier vector just wrote.
- Spread-out groups with CL > W, where a wrong group step moves every write to the wrong address.
- Address wrap at the top of memory.
- A count of 0 meaning 256.
- Keep-old and column selectors, including the clamp of the mask row and the column index to 3.
- Accumulate mode, which must feed each new sum into the next vector.
- Invalid formats, which must leave memory and the stream untouched.

// File: rtl/vu_unpack_pkg.sv
package vu_unpack_pkg;
  localparam int LANES  = 4;
  localparam int WORD_W = 32;
  localparam int VEC_W  = LANES * WORD_W;

  typedef logic [LANES-1:0][WORD_W-1:0] vec_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GATHER = 2'd1,
    ST_READ   = 2'd2,
    ST_WRITE  = 2'd3
  } state_e;
endpackage

// File: rtl/vu_elem_extract.sv
// Pulls one element out of a stream word at a bit offset, sign-extended,
// and also splits the low half of the word into four 5/5/5/1 lanes.
module vu_elem_extract
  import vu_unpack_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [4:0]        boff_i,
  input  logic [1:0]        vl_i,
  output logic [WORD_W-1:0] elem_o,
  output vec_t              pk5_o
);
  logic [WORD_W-1:0] shifted;

  always_comb begin
    shifted = word_i >> boff_i;
    unique case (vl_i)
      2'd1:    elem_o = {{(WORD_W-16){shifted[15]}}, shifted[15:0]};
      2'd2:    elem_o = {{(WORD_W-8){shifted[7]}}, shifted[7:0]};
      default: elem_o = shifted;
    endcase
  end

  assign pk5_o[0] = {{(WORD_W-5){word_i[4]}},  word_i[4:0]};
  assign pk5_o[1] = {{(WORD_W-5){word_i[9]}},  word_i[9:5]};
  assign pk5_o[2] = {{(WORD_W-5){word_i[14]}}, word_i[14:10]};
  assign pk5_o[3] = {WORD_W{word_i[15]}};
endmodule

// File: rtl/vu_lane_mix.sv
// Per-lane source select (input / row / column / keep) then row add.
module vu_lane_mix
  import vu_unpack_pkg::*;
(
  input  vec_t               src_i,
  input  vec_t               old_i,
  input  vec_t               row_i,
  input  logic [WORD_W-1:0]  col_i,
  input  logic [2*LANES-1:0] sel_i,
  input  logic [1:0]         mode_i,
  output vec_t               res_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [WORD_W-1:0] picked;
    always_comb begin
      unique case (sel_i[2*i +: 2])
        2'd1:    picked = row_i[i];
        2'd2:    picked = col_i;
        2'd3:    picked = old_i[i];
        default: picked = src_i[i];
      endcase
    end
    assign res_o[i] = (mode_i == 2'd1 || mode_i == 2'd2) ? picked + row_i[i] : picked;
  end
endmodule

// File: rtl/vu_unpack_engine.sv
module vu_unpack_engine
  import vu_unpack_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [4:0]        cmd_fmt,
  input  logic [7:0]        cmd_num,
  input  logic [15:0]       cmd_imm,
  input  logic [7:0]        cfg_cl,
  input  logic [7:0]        cfg_wl,
  input  logic [1:0]        cfg_mode,
  input  logic [31:0]       cfg_mask,
  input  logic [9:0]        cfg_tops,
  input  logic [VEC_W-1:0]  cfg_col,
  input  logic              row_ld,
  input  logic [VEC_W-1:0]  row_ld_data,
  output logic [VEC_W-1:0]  row_q,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [AW-1:0]     mem_addr,
  input  logic [VEC_W-1:0]  mem_rdata,
  output logic [VEC_W-1:0]  mem_wdata,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int POS_W = 9;  // holds 256

  state_e            state;
  logic [1:0]        vn_q, vl_q, eidx;
  logic              msk_q, zero_q;
  logic [POS_W-1:0]  vcnt, vtot, jpos;
  logic [AW-1:0]     base_q, blk_q;
  logic [4:0]        boff, estep;
  logic [WORD_W-1:0] wbuf, word_cur, elem;
  vec_t              unp_q, row_r, pk5, src_v, mix_v, col_v, old_v;

  logic [POS_W-1:0]  wl_eff;
  logic              skip_pos, have, last_elem, invalid;
  logic [1:0]        mrow, cidx;
  logic [2*LANES-1:0] sel_bits;
  logic [9:0]        base_calc;
  logic [AW-1:0]     cur_addr;

  assign wl_eff    = (cfg_wl == 8'd0) ? 9'd256 : {1'b0, cfg_wl};
  assign skip_pos  = ({1'b0, cfg_cl} < wl_eff) && (jpos >= {1'b0, cfg_cl});
  assign word_cur  = (boff == 5'd0) ? s_data : wbuf;
  assign s_ready   = (state == ST_GATHER) && !skip_pos && (boff == 5'd0);
  assign have      = (state == ST_GATHER) && !skip_pos && ((boff != 5'd0) || s_valid);
  assign last_elem = (vl_q == 2'd3) || (eidx == vn_q);
  assign invalid   = (cmd_fmt[1:0] == 2'd3) && (cmd_fmt[3:2] != 2'd3);
  assign base_calc = cmd_imm[9:0] + (cmd_imm[15] ? cfg_tops : 10'd0);
  assign cur_addr  = base_q + blk_q + AW'(jpos);
  assign mrow      = (jpos > 9'd3) ? 2'd3 : jpos[1:0];
  assign cidx      = (vcnt > 9'd3) ? 2'd3 : vcnt[1:0];
  assign sel_bits  = msk_q ? cfg_mask[{mrow, 3'b000} +: 2*LANES] : '0;
  assign col_v     = cfg_col;
  assign old_v     = mem_rdata;

  assign cmd_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign row_q     = row_r;

  always_comb begin
    unique case (vl_q)
      2'd1:    estep = 5'd16;
      2'd2:    estep = 5'd8;
      default: estep = 5'd0;
    endcase
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (zero_q)                 src_v[i] = '0;
      else if (vn_q == 2'd0)      src_v[i] = unp_q[0];
      else if (i <= int'(vn_q))   src_v[i] = unp_q[i];
      else                        src_v[i] = '0;
    end
  end

  vu_elem_extract u_extract (
    .word_i (word_cur),
    .boff_i (boff),
    .vl_i   (vl_q),
    .elem_o (elem),
    .pk5_o  (pk5)
  );

  vu_lane_mix u_mix (
    .src_i  (src_v),
    .old_i  (old_v),
    .row_i  (row_r),
    .col_i  (col_v[cidx]),
    .sel_i  (sel_bits),
    .mode_i (cfg_mode),
    .res_o  (mix_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      vn_q      <= '0;
      vl_q      <= '0;
      msk_q     <= 1'b0;
      eidx      <= '0;
      zero_q    <= 1'b0;
      vcnt      <= '0;
      vtot      <= '0;
      jpos      <= '0;
      base_q    <= '0;
      blk_q     <= '0;
      boff      <= '0;
      wbuf      <= '0;
      unp_q     <= '0;
      row_r     <= '0;
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      done      <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (row_ld) row_r <= row_ld_data;
          if (cmd_valid) begin
            err    <= invalid;
            vn_q   <= cmd_fmt[3:2];
            vl_q   <= cmd_fmt[1:0];
            msk_q  <= cmd_fmt[4];
            vtot   <= (cmd_num == 8'd0) ? 9'd256 : {1'b0, cmd_num};
            vcnt   <= '0;
            jpos   <= '0;
            blk_q  <= '0;
            base_q <= AW'(base_calc);
            boff   <= '0;
            eidx   <= '0;
            zero_q <= 1'b0;
            if (invalid) done  <= 1'b1;
            else         state <= ST_GATHER;
          end
        end
        ST_GATHER: begin
          if (skip_pos) begin
            zero_q    <= 1'b1;
            mem_rd_en <= 1'b1;
            mem_addr  <= cur_addr;
            state     <= ST_READ;
          end else if (have) begin
            if (boff == 5'd0) wbuf <= s_data;
            boff <= boff + estep;
            if (vl_q == 2'd3) unp_q <= pk5;
            else              unp_q[eidx] <= elem;
            eidx <= eidx + 2'd1;
            if (last_elem) begin
              eidx      <= '0;
              zero_q    <= 1'b0;
              mem_rd_en <= 1'b1;
              mem_addr  <= cur_addr;
              state     <= ST_READ;
            end
          end
        end
        ST_READ: state <= ST_WRITE;
        ST_WRITE: begin
          mem_wr_en <= 1'b1;
          mem_wdata <= mix_v;
          if (cfg_mode == 2'd2) row_r <= mix_v;
          zero_q <= 1'b0;
          vcnt   <= vcnt + 9'd1;
          if (jpos + 9'd1 == wl_eff) begin
            jpos  <= '0;
            blk_q <= blk_q + AW'(cfg_cl);
          end else begin
            jpos <= jpos + 9'd1;
          end
          if (vcnt + 9'd1 == vtot) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state <= ST_GATHER;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vu_unpack_engine_chk.sv
module vu_unpack_engine_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          s_ready,
  input logic          mem_rd_en,
  input logic          mem_wr_en,
  input logic [AW-1:0] mem_addr,
  input logic [127:0]  row_q,
  input logic [1:0]    cfg_mode
);
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en)); // R11

  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> ($past(mem_rd_en, 2) && mem_addr == $past(mem_addr, 2))); // R11

  AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> busy); // R10

  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    err |-> !mem_wr_en); // R9

  AST_ROW_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && $past(cfg_mode) != 2'd2) |-> $stable(row_q)); // R13
endmodule

bind vu_unpack_engine vu_unpack_engine_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .s_ready   (s_ready),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en),
  .mem_addr  (mem_addr),
  .row_q     (row_q),
  .cfg_mode  (cfg_mode)
);

// File: tb/vu_unpack_engine_tb_top.sv
module vu_unpack_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [4:0]  cmd_fmt = '0;
  logic [7:0]  cmd_num = '0;
  logic [15:0] cmd_imm = '0;
  logic [7:0]  cfg_cl = 8'd4, cfg_wl = 8'd4;
  logic [1:0]  cfg_mode = '0;
  logic [31:0] cfg_mask = '0;
  logic [9:0]  cfg_tops = '0;
  logic [127:0] cfg_col = '0;
  logic row_ld = 1'b0;
  logic [127:0] row_ld_data = '0;
  logic [127:0] row_q;
  logic s_valid, s_ready;
  logic [31:0] s_data;
  logic mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_addr;
  logic [127:0] mem_rdata, mem_wdata;
  logic busy, done, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  vu_unpack_engine #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_fmt(cmd_fmt), .cmd_num(cmd_num), .cmd_imm(cmd_imm),
    .cfg_cl(cfg_cl), .cfg_wl(cfg_wl), .cfg_mode(cfg_mode), .cfg_mask(cfg_mask),
    .cfg_tops(cfg_tops), .cfg_col(cfg_col), .row_ld(row_ld),
    .row_ld_data(row_ld_data), .row_q(row_q), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .busy(busy), .done(done), .err(err)
  );

  // memory model: one-cycle read latency
  logic [127:0] mem [DEPTH];
  logic [127:0] exp_mem [DEPTH];
  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  int wr_cnt = 0, rd_cnt = 0;
  always @(negedge clk) begin
    if (mem_wr_en) wr_cnt++;
    if (mem_rd_en) rd_cnt++;
  end

  // stream driver
  logic [31:0] stream_buf [1024];
  int stream_len = 0;
  int taken = 0;
  initial begin
    s_valid = 1'b0;
    s_data  = '0;
    forever begin
      logic fire;
      @(negedge clk);
      fire = s_valid && s_ready;
      @(posedge clk);
      #1;
      if (fire) taken++;
      if (taken < stream_len && $urandom_range(3) != 0) begin
        s_valid = 1'b1;
        s_data  = stream_buf[taken];
      end else begin
        s_valid = 1'b0;
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  // reference model state
  logic [31:0] exp_row [4];
  int  exp_words;
  bit  exp_err;

  function automatic logic [31:0] sx(input logic [31:0] v, input int w);
    logic [31:0] m;
    logic [31:0] x;
    m = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    x = v & m;
    if (w < 32 && x[w-1]) x = x | ~m;
    return x;
  endfunction

  task automatic model(input logic [4:0] fmt, input logic [7:0] num, input logic [15:0] imm);
    int vn, vl, wle, ntot, bitpos, base;
    bit msk;
    vn = int'(fmt[3:2]);
    vl = int'(fmt[1:0]);
    msk = fmt[4];
    wle = (cfg_wl == 0) ? 256 : int'(cfg_wl);
    ntot = (num == 0) ? 256 : int'(num);
    base = (int'(imm[9:0]) + (imm[15] ? int'(cfg_tops) : 0)) % 1024;
    bitpos = 0;
    exp_err = (vl == 3 && vn != 3);
    exp_words = 0;
    if (exp_err) return;
    for (int v = 0; v < ntot; v++) begin
      int j, addr, r, es;
      logic [31:0] src [4];
      logic [31:0] res [4];
      logic [31:0] w, picked;
      logic [1:0] sel;
      j = v % wle;
      addr = (base + int'(cfg_cl) * (v / wle) + j) % DEPTH;
      for (int i = 0; i < 4; i++) src[i] = '0;
      if (!(int'(cfg_cl) < wle && j >= int'(cfg_cl))) begin
        if (vl == 3) begin
          w = stream_buf[bitpos / 32];
          src[0] = sx(w, 5);
          src[1] = sx(w >> 5, 5);
          src[2] = sx(w >> 10, 5);
          src[3] = sx(w >> 15, 1);
          bitpos += 32;
        end else begin
          es = 32 >> vl;
          for (int e = 0; e <= vn; e++) begin
            w = stream_buf[bitpos / 32];
            src[e] = sx(w >> (bitpos % 32), es);
            bitpos += es;
          end
          if (vn == 0) for (int i = 1; i < 4; i++) src[i] = src[0];
        end
      end
      r = (j > 3) ? 3 : j;
      for (int i = 0; i < 4; i++) begin
        sel = msk ? cfg_mask[8*r + 2*i +: 2] : 2'd0;
        case (sel)
          2'd1: picked = exp_row[i];
          2'd2: picked = cfg_col[32*((v > 3) ? 3 : v) +: 32];
          2'd3: picked = exp_mem[addr][32*i +: 32];
          default: picked = src[i];
        endcase
        if (cfg_mode == 2'd1 || cfg_mode == 2'd2) picked = picked + exp_row[i];
        res[i] = picked;
        if (cfg_mode == 2'd2) exp_row[i] = picked;
      end
      exp_mem[addr] = {res[3], res[2], res[1], res[0]};
    end
    exp_words = (bitpos + 31) / 32;
  endtask

  task automatic load_rows(input logic [127:0] val);
    @(negedge clk);
    row_ld = 1'b1;
    row_ld_data = val;
    @(negedge clk);
    row_ld = 1'b0;
    for (int i = 0; i < 4; i++) exp_row[i] = val[32*i +: 32];
  endtask

  task automatic run_cmd(input string tag, input logic [4:0] fmt, input logic [7:0] num,
                         input logic [15:0] imm, input bit poke_row);
    int guard, wr0, rd0, ntot, mism, first;
    logic [127:0] rowexp;
    for (int k = 0; k < 1024; k++) stream_buf[k] = $urandom;
    model(fmt, num, imm);
    ntot = exp_err ? 0 : ((num == 0) ? 256 : int'(num));
    @(negedge clk);
    taken = 0;
    stream_len = exp_words + 4;
    wr0 = wr_cnt;
    rd0 = rd_cnt;
    cmd_fmt = fmt;
    cmd_num = num;
    cmd_imm = imm;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (poke_row && guard == 3) begin
        row_ld = 1'b1;
        row_ld_data = {4{32'hDEAD_0001}};
      end else begin
        row_ld = 1'b0;
      end
    end
    row_ld = 1'b0;
    check(tag, "command completion", {127'd0, done}, 128'd1);
    @(negedge clk);
    mism = 0;
    first = -1;
    for (int k = 0; k < DEPTH; k++) begin
      if (mem[k] !== exp_mem[k]) begin
        mism++;
        if (first < 0) first = k;
      end
    end
    if (first >= 0)
      $display("  first memory difference at %0d: %h vs %h", first, mem[first], exp_mem[first]);
    check(tag, "memory mismatches", 128'(mism), 128'd0);
    rowexp = {exp_row[3], exp_row[2], exp_row[1], exp_row[0]};
    check("R8 R13", "row registers", row_q, rowexp);
    check("R10", "stream words taken", 128'(taken), 128'(exp_words));
    check("R9", "error flag", {127'd0, err}, {127'd0, exp_err});
    check("R11", "write count", 128'(wr_cnt - wr0), 128'(ntot));
    check("R11", "read count", 128'(rd_cnt - rd0), 128'(ntot));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < DEPTH; k++) begin
      logic [127:0] v;
      v = {$urandom, $urandom, $urandom, $urandom};
      mem[k] <= v;
      exp_mem[k] = v;
    end
    for (int i = 0; i < 4; i++) exp_row[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    check("R12", "cmd_ready after reset", {127'd0, cmd_ready}, 128'd1);
    check("R12", "busy/err/wr/s_ready after reset",
          {124'd0, busy, err, mem_wr_en, s_ready}, 128'd0);
    check("R13", "row registers after reset", row_q, 128'd0);

    // R1: four 32-bit elements
    cfg_cl = 8'd4; cfg_wl = 8'd4; cfg_mode = 2'd0;
    run_cmd("R1", 5'b0_11_00, 8'd3, 16'd10, 1'b0);
    // R2 R4: scalar 16-bit broadcast, offset carried between vectors
    run_cmd("R2 R4", 5'b0_00_01, 8'd5, 16'd40, 1'b0);
    // R2 R4: three 8-bit elements, lane 3 zero
    run_cmd("R2 R4", 5'b0_10_10, 8'd6, 16'd60, 1'b0);
    // R3: packed 5/5/5/1
    run_cmd("R3", 5'b0_11_11, 8'd4, 16'd80, 1'b0);
    // R9: invalid format
    run_cmd("R9", 5'b1_01_11, 8'd4, 16'd100, 1'b0);
    // R6 R7 R8: fill mode with overlapping writes, masked, accumulate
    load_rows({32'd4, 32'd3, 32'd2, 32'd1});
    cfg_cl = 8'd1; cfg_wl = 8'd3; cfg_mode = 2'd2;
    cfg_mask = 32'h1B_E4_93_6C;
    cfg_col = {32'hC3, 32'hC2, 32'hC1, 32'hC0};
    run_cmd("R6 R7 R8", 5'b1_01_01, 8'd7, 16'd120, 1'b0);
    // R5 R8: spread groups CL > WL, add row
    cfg_cl = 8'd4; cfg_wl = 8'd2; cfg_mode = 2'd1;
    run_cmd("R5 R8", 5'b0_11_10, 8'd6, 16'd200, 1'b0);
    // R5: TOPS-relative start wrapping at the top of memory
    cfg_cl = 8'd4; cfg_wl = 8'd4; cfg_mode = 2'd0; cfg_tops = 10'd20;
    run_cmd("R5", 5'b0_11_00, 8'd8, {1'b1, 5'd0, 10'd1000}, 1'b0);
    // R5 R10: count 0 means 256
    run_cmd("R5 R10", 5'b0_00_10, 8'd0, 16'd300, 1'b0);
    // R7 R13: all selectors incl. keep-old, row load poked while busy
    cfg_mask = 32'hFF_AA_55_E4; cfg_mode = 2'd1;
    run_cmd("R7 R13", 5'b1_11_00, 8'd6, 16'd600, 1'b1);

    // constrained random commands
    for (int t = 0; t < 24; t++) begin
      cfg_cl   = 8'($urandom_range(0, 6));
      cfg_wl   = 8'($urandom_range(0, 6));
      cfg_mode = 2'($urandom_range(0, 3));
      cfg_mask = $urandom;
      cfg_tops = 10'($urandom);
      cfg_col  = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(1) == 1) load_rows({$urandom, $urandom, $urandom, $urandom});
      run_cmd("R1 R5 R7", 5'($urandom), 8'($urandom_range(1, 24)), 16'($urandom),
              ($urandom_range(3) == 0));
    end

    summary();
    $finish;
  end
endmodule